// File: doc/BRIEF.md
# Control-Flow Resolution Checker

This block sits in the execute stage beside the target adder. Each control-flow instruction reaches it with three things: the kind of instruction it really is (conditional branch, direct jump, indirect jump), the outcome computed for it (taken flag and target), and what the fetch side predicted for it (a predicted kind, a predicted address, and whether the return-address stack had a live entry). One cycle later the block reports whether fetch went down the wrong path, together with the address that execution must continue from.

A return whose stack lookup was empty is never treated as a prediction. Its predicted address carries no meaning, often all zeros. If the block compared that address anyway, a return whose true destination is zero would look correctly predicted. Fetch would then run on in sequence while the back end believed a jump had happened. The block demotes such a return to "not predicted", so it always raises a redirect. The same rule applies wherever fetch did not follow a taken transfer: a flush is always raised.

The block is a two-state machine. `S_IDLE` means no result is on the outputs. `S_REPORT` means a result is on the outputs. The transitions are: `S_IDLE` to `S_REPORT` on an accepted request, `S_REPORT` to `S_REPORT` on a back-to-back request, `S_REPORT` to `S_IDLE` when no request arrives, and `S_IDLE` to `S_IDLE` otherwise.

Top module: `brc_resolver`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `out_valid` and `out_mispredict` are 0 and `out_target` is zero.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1. In every other cycle, `out_valid` and `out_mispredict` are 0 and `out_target` is zero.
- R3: For a conditional branch (`op_kind` = 2'b00), a mispredict is raised when the actual taken flag differs from the predicted direction. The predicted direction is "taken" exactly when `pred_type` = 3'd1.
- R4: For a conditional branch that is taken and was predicted taken, a mispredict is raised exactly when `pred_addr` differs from `res_target`.
- R5: For a conditional branch, `out_target` is `res_target` when the branch is taken. When it is not taken, `out_target` is `in_pc`+2 if `in_rvc` is 1 and `in_pc`+4 otherwise, computed modulo 2^XLEN.
- R6: A direct jump (`op_kind` = 2'b01) predicted as a jump (`pred_type` = 3'd2) never raises a mispredict, whatever `pred_addr` holds. Its `out_target` is `res_target`.
- R7: A direct jump with any other `pred_type` raises a mispredict, because fetch did not follow it.
- R8: For an indirect jump (`op_kind` = 2'b10 or 2'b11) predicted as jump-register (`pred_type` = 3'd3), or as a return (`pred_type` = 3'd4) with `pred_stack_ok` = 1, a mispredict is raised exactly when `pred_addr` differs from `res_target`. Its `out_target` is `res_target`.
- R9: A return prediction with `pred_stack_ok` = 0 counts as no prediction. An indirect jump carrying it always raises a mispredict, including when `res_target` and `pred_addr` are both zero.
- R10: An indirect jump whose `pred_type` is none (3'd0), branch (3'd1), jump (3'd2) or a reserved code (3'd5 to 3'd7) always raises a mispredict. Reserved codes mean "none" for every instruction kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A control-flow instruction is presented |
| in_pc | input | XLEN | Address of the instruction |
| in_rvc | input | 1 | Instruction is 16 bits long |
| op_kind | input | 2 | Actual kind: 00 branch, 01 direct jump, 1x indirect jump |
| res_taken | input | 1 | Computed branch outcome (used for branches only) |
| res_target | input | XLEN | Computed transfer target |
| pred_type | input | 3 | Predicted kind: 0 none, 1 branch taken, 2 jump, 3 jump-register, 4 return |
| pred_stack_ok | input | 1 | Return-address stack had a live entry |
| pred_addr | input | XLEN | Predicted target address |
| out_valid | output | 1 | Resolution result present |
| out_mispredict | output | 1 | Fetch path was wrong; flush and redirect |
| out_target | output | XLEN | Address to continue from |

## Verification
The checker assumes that `in_valid` is 0 throughout reset, and that all request fields are stable around the sampling edge whenever `in_valid` is 1. The bench drives every field on the falling edge and drops `in_valid` during reset. It sweeps every instruction kind, every predicted-type code, both stack states, both outcomes and both instruction lengths. Each of these is paired with a matching predicted address, a mismatching one, and the all-zero target and prediction. The sweep also includes a PC that wraps past the top of the address space.

// File: rtl/brc_pkg.sv
package brc_pkg;

    // actual instruction kind (op_kind[1] set means indirect)
    localparam logic [1:0] OPK_BRANCH = 2'b00;
    localparam logic [1:0] OPK_DIRECT = 2'b01;

    // raw predicted-type codes from fetch
    localparam logic [2:0] PT_NONE    = 3'd0;
    localparam logic [2:0] PT_BRANCH  = 3'd1;
    localparam logic [2:0] PT_JUMP    = 3'd2;
    localparam logic [2:0] PT_JUMPREG = 3'd3;
    localparam logic [2:0] PT_RETURN  = 3'd4;

    // prediction after trust filtering
    typedef enum logic [1:0] {
        PC_NONE     = 2'd0,
        PC_TAKEN    = 2'd1,
        PC_DIRECT   = 2'd2,
        PC_INDIRECT = 2'd3
    } pred_class_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } brc_state_e;

endpackage

// File: rtl/brc_pred_filter.sv
// Turns the raw predicted type into a trusted prediction class.
// A return without a live stack entry is demoted to no prediction.
module brc_pred_filter
    import brc_pkg::*;
(
    input  logic [2:0]  pred_type,
    input  logic        pred_stack_ok,
    output pred_class_e pred_class
);
    always_comb begin
        unique case (pred_type)
            PT_BRANCH:  pred_class = PC_TAKEN;
            PT_JUMP:    pred_class = PC_DIRECT;
            PT_JUMPREG: pred_class = PC_INDIRECT;
            PT_RETURN:  pred_class = pred_stack_ok ? PC_INDIRECT : PC_NONE;
            default:    pred_class = PC_NONE;
        endcase
    end
endmodule

// File: rtl/brc_fallthrough.sv
// Sequential successor address of the instruction.
module brc_fallthrough #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic            rvc,
    output logic [XLEN-1:0] next_pc
);
    localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);
    localparam logic [XLEN-1:0] STEP_FULL  = XLEN'(4);

    always_comb begin
        next_pc = pc + (rvc ? STEP_SHORT : STEP_FULL);
    end
endmodule

// File: rtl/brc_judge.sv
// Decides mispredict and continuation address for one instruction.
module brc_judge
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op_kind,
    input  pred_class_e     pred_class,
    input  logic            res_taken,
    input  logic [XLEN-1:0] res_target,
    input  logic [XLEN-1:0] pred_addr,
    input  logic [XLEN-1:0] seq_pc,
    output logic            mispredict,
    output logic [XLEN-1:0] target
);
    logic addr_differs;
    logic guessed_taken;

    always_comb begin
        addr_differs  = (pred_addr != res_target);
        guessed_taken = (pred_class == PC_TAKEN);
        mispredict    = 1'b0;
        target        = res_target;
        if (op_kind[1]) begin
            // indirect: only a trusted indirect guess with a matching address passes
            mispredict = (pred_class != PC_INDIRECT) || addr_differs;
        end else if (op_kind == OPK_DIRECT) begin
            // direct: passes whenever fetch actually redirected
            mispredict = (pred_class != PC_DIRECT);
        end else begin
            mispredict = (res_taken != guessed_taken)
                       || (res_taken && guessed_taken && addr_differs);
            target     = res_taken ? res_target : seq_pc;
        end
    end
endmodule

// File: rtl/brc_resolver.sv
module brc_resolver
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_pc,
    input  logic            in_rvc,
    input  logic [1:0]      op_kind,
    input  logic            res_taken,
    input  logic [XLEN-1:0] res_target,
    input  logic [2:0]      pred_type,
    input  logic            pred_stack_ok,
    input  logic [XLEN-1:0] pred_addr,
    output logic            out_valid,
    output logic            out_mispredict,
    output logic [XLEN-1:0] out_target
);
    brc_state_e      state_q, state_d;
    pred_class_e     pclass;
    logic [XLEN-1:0] seq_pc;
    logic            judge_misp;
    logic [XLEN-1:0] judge_tgt;
    logic            misp_q;
    logic [XLEN-1:0] tgt_q;

    brc_pred_filter u_filter (
        .pred_type     (pred_type),
        .pred_stack_ok (pred_stack_ok),
        .pred_class    (pclass)
    );

    brc_fallthrough #(.XLEN(XLEN)) u_seq (
        .pc      (in_pc),
        .rvc     (in_rvc),
        .next_pc (seq_pc)
    );

    brc_judge #(.XLEN(XLEN)) u_judge (
        .op_kind    (op_kind),
        .pred_class (pclass),
        .res_taken  (res_taken),
        .res_target (res_target),
        .pred_addr  (pred_addr),
        .seq_pc     (seq_pc),
        .mispredict (judge_misp),
        .target     (judge_tgt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = in_valid ? S_REPORT : S_IDLE;
            S_REPORT: state_d = in_valid ? S_REPORT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // output register: hold a result only for the reporting cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            misp_q <= 1'b0;
            tgt_q  <= '0;
        end else begin
            misp_q <= judge_misp;
            tgt_q  <= judge_tgt;
        end
    end

    assign out_valid      = (state_q == S_REPORT);
    assign out_mispredict = misp_q;
    assign out_target     = tgt_q;
endmodule

// File: rtl/brc_resolver_chk.sv
module brc_resolver_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] in_pc,
    input logic            in_rvc,
    input logic [1:0]      op_kind,
    input logic            res_taken,
    input logic [XLEN-1:0] res_target,
    input logic [2:0]      pred_type,
    input logic            pred_stack_ok,
    input logic [XLEN-1:0] pred_addr,
    input logic            out_valid,
    input logic            out_mispredict,
    input logic [XLEN-1:0] out_target
);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_mispredict && out_target == '0));

    // R6
    direct_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'b01 && pred_type == 3'd2) |=> !out_mispredict);

    // R9
    empty_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind[1] && pred_type == 3'd4 && !pred_stack_ok) |=> out_mispredict);

    // R8
    indirect_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind[1] && pred_addr != res_target
         && (pred_type == 3'd3 || (pred_type == 3'd4 && pred_stack_ok)))
        |=> out_mispredict);

    // R5
    fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'b00 && !res_taken)
        |=> out_target == $past(in_pc) + ($past(in_rvc) ? XLEN'(2) : XLEN'(4)));
endmodule

bind brc_resolver brc_resolver_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_pc          (in_pc),
    .in_rvc         (in_rvc),
    .op_kind        (op_kind),
    .res_taken      (res_taken),
    .res_target     (res_target),
    .pred_type      (pred_type),
    .pred_stack_ok  (pred_stack_ok),
    .pred_addr      (pred_addr),
    .out_valid      (out_valid),
    .out_mispredict (out_mispredict),
    .out_target     (out_target)
);

// File: tb/brc_resolver_test.sv
module brc_resolver_test;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [XLEN-1:0] in_pc = '0;
    logic            in_rvc = 1'b0;
    logic [1:0]      op_kind = 2'b00;
    logic            res_taken = 1'b0;
    logic [XLEN-1:0] res_target = '0;
    logic [2:0]      pred_type = 3'd0;
    logic            pred_stack_ok = 1'b0;
    logic [XLEN-1:0] pred_addr = '0;
    logic            out_valid;
    logic            out_mispredict;
    logic [XLEN-1:0] out_target;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    brc_resolver #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_rvc(in_rvc), .op_kind(op_kind), .res_taken(res_taken),
        .res_target(res_target), .pred_type(pred_type),
        .pred_stack_ok(pred_stack_ok), .pred_addr(pred_addr),
        .out_valid(out_valid), .out_mispredict(out_mispredict),
        .out_target(out_target)
    );

    task automatic check(input string tag, input logic v, input logic m,
                         input logic [XLEN-1:0] t);
        checks++;
        if (out_valid !== v || out_mispredict !== m || out_target !== t) begin
            errors++;
            $display("FAIL %s: got v=%0b m=%0b t=%h, expected v=%0b m=%0b t=%h",
                     tag, out_valid, out_mispredict, out_target, v, m, t);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int idx = 0;
        // R1: outputs quiet during and right after reset
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 1'b0, '0);

        for (int k = 0; k < 4; k++)
        for (int pt = 0; pt < 8; pt++)
        for (int so = 0; so < 2; so++)
        for (int tk = 0; tk < 2; tk++)
        for (int rv = 0; rv < 2; rv++)
        for (int sc = 0; sc < 3; sc++) begin
            logic [XLEN-1:0] pc, tg, pa, exp_t;
            logic exp_m, ptaken;
            int cls; // 0 none, 1 taken, 2 direct, 3 indirect
            string tag;
            idx++;
            pc = (idx % 97 == 0) ? 32'hFFFF_FFFE : 32'h0000_1000 + idx * 6;
            tg = 32'h0000_2000 + idx * 4;
            pa = tg;
            if (sc == 1) pa = tg ^ 32'h10;
            if (sc == 2) begin tg = '0; pa = '0; end

            if (pt == 1) cls = 1;
            else if (pt == 2) cls = 2;
            else if (pt == 3 || (pt == 4 && so == 1)) cls = 3;
            else cls = 0;

            exp_t = tg;
            if (k == 0) begin
                ptaken = (cls == 1);
                exp_m = (tk[0] != ptaken) || (tk[0] && ptaken && pa != tg);
                if (!tk[0]) exp_t = pc + ((rv == 1) ? 32'd2 : 32'd4);
                if (tk[0] != ptaken) tag = "R3";
                else if (tk[0]) tag = "R4";
                else tag = "R5";
            end else if (k == 1) begin
                exp_m = (cls != 2);
                tag = (cls == 2) ? "R6" : "R7";
            end else begin
                exp_m = (cls != 3) || (pa != tg);
                if (pt == 4 && so == 0) tag = "R9";
                else if (cls == 3) tag = "R8";
                else tag = "R10";
            end

            in_valid = 1'b1; in_pc = pc; in_rvc = rv[0]; op_kind = k[1:0];
            res_taken = tk[0]; res_target = tg; pred_type = pt[2:0];
            pred_stack_ok = so[0]; pred_addr = pa;
            @(negedge clk);
            in_valid = 1'b0;
            check(tag, 1'b1, exp_m, exp_t);
            // garbage on idle inputs must not leak out
            res_target = 32'hDEAD_BEEF; pred_addr = '0;
            @(negedge clk);
            check("R2", 1'b0, 1'b0, '0);
        end

        // R2: back-to-back requests keep out_valid high each cycle
        in_valid = 1'b1; op_kind = 2'b01; pred_type = 3'd2; res_target = 32'h40;
        @(negedge clk);
        check("R6", 1'b1, 1'b0, 32'h40);
        op_kind = 2'b10; pred_type = 3'd4; pred_stack_ok = 1'b0;
        res_target = '0; pred_addr = '0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", 1'b1, 1'b1, '0);
        @(negedge clk);
        check("R2", 1'b0, 1'b0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule